// File: doc/BRIEF.md
# Coin Credit Vending Controller

This block is the control core of a gum dispenser. It counts the money put in through two coin-sensor strobes. One strobe reports a nickel and the other reports a dime, and each is high for a single clock per coin. The credit is kept as one of four values: zero, five, ten or fifteen cents. When the credit reaches fifteen cents or more, the release output goes high.

The fifteen-cent state saturates, so an overpayment such as twenty cents still lands there. The machine stays in that state until external logic clears it with a reset after the gum has been delivered. The machine never clears itself.

Release is decoded from the registered state alone. As a result it changes only at clock edges and does not follow the coin strobes combinationally. The encoded credit state is also brought out to the ports so that tests can see it.

Top module: `vend_credit_fsm`

## Requirements
- R1: A low `rst_n` sampled at a rising edge sets the credit state to 2'b00 and release low after that edge. This takes priority over any coin strobe in the same cycle.
- R2: From 0 cents (2'b00), a nickel moves the state to 5 cents (2'b01) and a dime moves it to 10 cents (2'b10) at the next edge.
- R3: From 5 cents (2'b01), a nickel moves the state to 10 cents (2'b10) and a dime moves it to 15 cents (2'b11).
- R4: From 10 cents (2'b10), either a nickel or a dime moves the state to 15 cents (2'b11). A dime at 10 cents, which is 20 cents of credit, also lands at 2'b11.
- R5: When neither strobe is high, the state keeps its value across the edge.
- R6: `release_o` is high exactly when the state is 2'b11. It changes only at clock edges, never between edges in response to the coin inputs.
- R7: In the 15-cent state, further coins are ignored. The state stays at 2'b11 until a reset.
- R8: If both strobes are high in the same cycle, the nickel is ignored and the input is handled as a dime.
- R9: `credit_state_o` carries the encoding 0 cents = 2'b00, 5 cents = 2'b01, 10 cents = 2'b10 and 15 cents = 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| nickel_i | input | 1 | One-cycle strobe: nickel accepted |
| dime_i | input | 1 | One-cycle strobe: dime accepted |
| release_o | output | 1 | High while 15 cents or more has been credited |
| credit_state_o | output | 2 | Encoded credit state |

## Verification
Two events can fall in the same cycle. The first is the external clear and a coin strobe: the bench holds `rst_n` low together with a nickel or a dime, and it expects 2'b00 after the edge. The second is a nickel together with a dime, driven both from directed states and at random, where the bench expects the dime transition. A bench function models the transitions, and the state and release are compared a quarter period after every edge. Release is also sampled just after new coin inputs are driven, before the edge, to confirm that it has not yet moved.

// File: rtl/vend_credit_pkg.sv
// Package: shared types for the coin credit controller.
// Assumes the fixed four-level credit scale of 0/5/10/15 cents.
package vend_credit_pkg;

    localparam int STATE_W = 2;

    // Credit levels; the encoding is visible at the top-level port.
    typedef enum logic [STATE_W-1:0] {
        CR_ZERO = 2'b00,
        CR_FIVE = 2'b01,
        CR_TEN  = 2'b10,
        CR_FULL = 2'b11
    } credit_t;

    // Coin event after the two sensor strobes are resolved.
    typedef enum logic [1:0] {
        COIN_NONE   = 2'b00,
        COIN_NICKEL = 2'b01,
        COIN_DIME   = 2'b10
    } coin_t;

endpackage

// File: rtl/vend_coin_decode.sv
// Module: turns the two coin strobes into a single coin event.
// Assumes the strobes are synchronous to clk. If both are high together,
// the dime wins and the nickel is dropped.
module vend_coin_decode
    import vend_credit_pkg::*;
(
    input  logic  nickel_i,
    input  logic  dime_i,
    output coin_t coin_o
);

    // Resolve the strobes with dime priority.
    always_comb begin
        if (dime_i)
            coin_o = COIN_DIME;
        else if (nickel_i)
            coin_o = COIN_NICKEL;
        else
            coin_o = COIN_NONE;
    end

endmodule

// File: rtl/vend_credit_next.sv
// Module: next-state function of the credit machine.
// Assumes one resolved coin event per cycle. Saturates at the full level.
module vend_credit_next
    import vend_credit_pkg::*;
(
    input  credit_t cur_i,
    input  coin_t   coin_i,
    output credit_t nxt_o
);

    // Advance the credit by the coin value, clamping at full.
    always_comb begin
        nxt_o = cur_i;
        unique case (cur_i)
            CR_ZERO: begin
                if (coin_i == COIN_NICKEL)    nxt_o = CR_FIVE;
                else if (coin_i == COIN_DIME) nxt_o = CR_TEN;
            end
            CR_FIVE: begin
                if (coin_i == COIN_NICKEL)    nxt_o = CR_TEN;
                else if (coin_i == COIN_DIME) nxt_o = CR_FULL;
            end
            CR_TEN: begin
                if (coin_i != COIN_NONE)      nxt_o = CR_FULL;
            end
            CR_FULL: begin
                nxt_o = CR_FULL;
            end
            default: nxt_o = CR_ZERO;
        endcase
    end

endmodule

// File: rtl/vend_credit_reg.sv
// Module: the credit state register with a synchronous active-low clear.
// Assumes rst_n is synchronous to clk.
module vend_credit_reg
    import vend_credit_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  credit_t nxt_i,
    output credit_t cur_o
);

    // Load the next state, or clear to zero while reset is low.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_o <= CR_ZERO;
        else
            cur_o <= nxt_i;
    end

endmodule

// File: rtl/vend_release_decode.sv
// Module: Moore output decode. Release is a function of the stored state only.
// Assumes cur_i comes straight from the state register.
module vend_release_decode
    import vend_credit_pkg::*;
(
    input  credit_t cur_i,
    output logic    release_o
);

    // Release only at the full credit level.
    always_comb begin
        release_o = (cur_i == CR_FULL);
    end

endmodule

// File: rtl/vend_credit_fsm.sv
// Top: coin credit controller for a gum dispenser.
// Counts nickels and dimes up to 15 cents and raises release when the
// credit is full. It holds that level until an external synchronous reset.
// Assumes one-cycle coin strobes, synchronous to clk.
module vend_credit_fsm
    import vend_credit_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               nickel_i,
    input  logic               dime_i,
    output logic               release_o,
    output logic [STATE_W-1:0] credit_state_o
);

    coin_t   coin;
    credit_t cur_state;
    credit_t nxt_state;

    vend_coin_decode u_coin (
        .nickel_i (nickel_i),
        .dime_i   (dime_i),
        .coin_o   (coin)
    );

    vend_credit_next u_next (
        .cur_i  (cur_state),
        .coin_i (coin),
        .nxt_o  (nxt_state)
    );

    vend_credit_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .nxt_i (nxt_state),
        .cur_o (cur_state)
    );

    vend_release_decode u_rel (
        .cur_i     (cur_state),
        .release_o (release_o)
    );

    // Expose the encoded state for test visibility.
    always_comb begin
        credit_state_o = cur_state;
    end

endmodule

// File: rtl/vend_credit_fsm_chk.sv
// Checker: temporal properties of the coin credit controller, seen at its ports.
module vend_credit_fsm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       nickel_i,
    input logic       dime_i,
    input logic       release_o,
    input logic [1:0] credit_state_o
);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (credit_state_o == 2'b00 && !release_o));

    // R2
    zero_nickel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (credit_state_o == 2'b00 && nickel_i && !dime_i) |=> credit_state_o == 2'b01);

    // R3
    five_dime_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (credit_state_o == 2'b01 && dime_i) |=> credit_state_o == 2'b11);

    // R4
    ten_any_coin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (credit_state_o == 2'b10 && (nickel_i || dime_i)) |=> credit_state_o == 2'b11);

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!nickel_i && !dime_i) |=> $stable(credit_state_o));

    // R6
    release_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        release_o == (credit_state_o == 2'b11));

    // R7
    full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (credit_state_o == 2'b11) |=> (credit_state_o == 2'b11 && release_o));

    // R8
    both_as_dime_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (credit_state_o == 2'b00 && nickel_i && dime_i) |=> credit_state_o == 2'b10);

endmodule

bind vend_credit_fsm vend_credit_fsm_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .nickel_i       (nickel_i),
    .dime_i         (dime_i),
    .release_o      (release_o),
    .credit_state_o (credit_state_o)
);

// File: tb/tb_vend_credit_fsm.sv
// Bench: directed corner cases plus seeded random coin traffic, checked
// against a transition model written from the requirements.
module tb_vend_credit_fsm;

    localparam int CLK_PERIOD = 10;
    localparam int RAND_CYCLES = 3000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nickel = 1'b0;
    logic       dime = 1'b0;
    logic       release_w;
    logic [1:0] credit_w;

    int checks = 0;
    int errors = 0;
    logic [1:0] exp_state = 2'b00;

    always #(CLK_PERIOD/2) clk = ~clk;

    vend_credit_fsm dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .nickel_i       (nickel),
        .dime_i         (dime),
        .release_o      (release_w),
        .credit_state_o (credit_w)
    );

    // Model: credit in cents, clamped at 15; a dime wins over a nickel.
    function automatic logic [1:0] model_next(input logic [1:0] s, input logic n, input logic d);
        int cents;
        cents = int'(s) * 5;
        if (d)      cents = cents + 10;
        else if (n) cents = cents + 5;
        if (cents > 15) cents = 15;
        return 2'(cents / 5);
    endfunction

    task automatic check(input string req, input logic [1:0] act_s, input logic act_r,
                         input logic [1:0] e_s, input logic e_r);
        checks++;
        if (act_s !== e_s || act_r !== e_r) begin
            errors++;
            $display("FAIL %s: state=%b release=%b expected state=%b release=%b",
                     req, act_s, act_r, e_s, e_r);
        end
    endtask

    // One clock: drive at negedge, check release has not moved (R6), check after edge.
    task automatic cycle(input logic rn, input logic n, input logic d, input string req);
        logic [1:0] prev;
        @(negedge clk);
        rst_n = rn; nickel = n; dime = d;
        prev = exp_state;
        exp_state = rn ? model_next(exp_state, n, d) : 2'b00;
        #1;
        check("R6 no combinational release", credit_w, release_w, prev, prev == 2'b11);
        @(posedge clk);
        #(CLK_PERIOD/4);
        check(req, credit_w, release_w, exp_state, exp_state == 2'b11);
    endtask

    task automatic reach(input logic [1:0] target);
        cycle(1'b0, 1'b0, 1'b0, "R1 reset");
        if (target == 2'b01) cycle(1'b1, 1'b1, 1'b0, "R2 setup");
        if (target == 2'b10) cycle(1'b1, 1'b0, 1'b1, "R2 setup");
        if (target == 2'b11) begin
            cycle(1'b1, 1'b0, 1'b1, "R2 setup");
            cycle(1'b1, 1'b0, 1'b1, "R4 setup");
        end
    endtask

    initial begin
        void'($urandom(32'd4711));
        cycle(1'b0, 1'b0, 1'b0, "R1 reset state");
        cycle(1'b0, 1'b0, 1'b0, "R9 zero encoding");
        reach(2'b00); cycle(1'b1, 1'b1, 1'b0, "R2 zero+nickel");
        cycle(1'b1, 1'b0, 1'b0, "R5 idle hold at five");
        reach(2'b00); cycle(1'b1, 1'b0, 1'b1, "R2 zero+dime");
        reach(2'b01); cycle(1'b1, 1'b1, 1'b0, "R3 five+nickel");
        reach(2'b01); cycle(1'b1, 1'b0, 1'b1, "R3 five+dime");
        reach(2'b10); cycle(1'b1, 1'b1, 1'b0, "R4 ten+nickel");
        reach(2'b10); cycle(1'b1, 1'b0, 1'b1, "R4 ten+dime overpay");
        cycle(1'b1, 1'b1, 1'b0, "R7 full ignores nickel");
        cycle(1'b1, 1'b0, 1'b1, "R7 full ignores dime");
        cycle(1'b1, 1'b0, 1'b0, "R7 full holds idle");
        cycle(1'b0, 1'b1, 1'b0, "R1 reset beats nickel");
        reach(2'b00); cycle(1'b1, 1'b1, 1'b1, "R8 both as dime from zero");
        reach(2'b01); cycle(1'b1, 1'b1, 1'b1, "R8 both as dime from five");
        reach(2'b10); cycle(1'b0, 1'b0, 1'b1, "R1 reset beats dime");
        cycle(1'b1, 1'b0, 1'b0, "R5 idle hold at zero");
        for (int i = 0; i < RAND_CYCLES; i++) begin
            int r;
            logic rn, n, d;
            r  = int'($urandom_range(0, 31));
            rn = (r != 0);
            n  = (r >= 1 && r <= 8) || r == 31;
            d  = (r >= 9 && r <= 14) || r == 31;
            cycle(rn, n, d, "R9 random traffic");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule